// File: doc/BRIEF.md
# Predicated Macro Sequencer with Hardware Loop

This block steers the instruction pointer of a small macro engine. Each cycle it presents an address to an instruction memory and takes back one 44-bit instruction word in the same cycle. It turns the predicate field of that word into four enable strobes. The strobes go to two ALU slots and two output slots. The block then works out where execution goes next. The next address can come from plain sequential flow, a conditional branch, an unconditional jump or a single counted loop that costs no cycles. Execution can end through a reserved branch offset or through a delayed end flag. The ALU datapath and the output buffering sit outside the block. The ALU slots feed it one compare outcome and one loop operand each.

A run starts with a `go` pulse while the block is idle and always begins at address 0. The run continues until a normal halt, which raises `done`, or a fault, which raises `fault`. An illegal loop request raises the sticky `loop_err` flag but does not stop the run.

Instruction word fields, LSB first: `[15:0]` immediate of ALU slot 0, `[31:16]` immediate of ALU slot 1, `[34:32]` opcode of slot 0, `[37:35]` opcode of slot 1, `[41:38]` expected truth per slot (bit 38 + i for slot i), `[42]` unconditional, `[43]` end-after-next. Opcodes: 1 branch, 2 jump, 3 loop, 4 state read. Every other code is a plain ALU operation with no effect on control flow.

Top module: `macro_seq`

## Requirements
- R1: Reset values. After reset, `busy`, `done`, `fault` and `loop_err` are 0, `slot_en` is 0 and `imem_addr` is 0.
- R2: Starting a run. `go` sampled while idle starts a run on the next edge: `busy` goes to 1, the address goes to 0, and `done`, `fault`, `loop_err` and the loop state are cleared. `go` has no effect while busy. While idle, `imem_addr` holds its value.
- R3: Slot enables. `slot_en` bit 0 drives ALU0, bit 1 drives ALU1, bit 2 drives output 0 and bit 3 drives output 1. When bit 42 is set, all four bits are 1. Otherwise bit i is 1 exactly when instruction bit 38+i equals (`pred_value` != 0). While idle, `slot_en` is 0.
- R4: Sequential flow. With no redirect, no loop-back and no halt, the next address is the current address plus 1.
- R5: Branch. Opcode 1 in an enabled ALU slot i is taken when `cmp_result[i]` equals immediate bit 15. The target is the address plus immediate bits [12:0], sign-extended. If both slots redirect, slot 1 wins.
- R6: Stop code. A taken branch whose bits [12:0] equal 13'h1000 does not jump. It halts the run with `done`=1 after the current instruction.
- R7: Jump. Opcode 2 in an enabled slot jumps to the address plus immediate bits [14:0], treated as unsigned. If immediate bit 15 is 0, the jump faults.
- R8: Faults. A branch or jump target outside 0..2^IP_W-1, or sequential flow past the top address, halts the run with `fault`=1. The address is not updated.
- R9: Starting a loop. Opcode 3 in an enabled slot i starts a loop with count max(1, x)-1, where x is `loop_val0` or `loop_val1`. The loop start is the current address and the loop end is the address plus immediate - 1. `loop_err` is set and no loop starts in any of these cases: a count is already nonzero, the immediate is below 2, the end lies beyond the top address, or slot 1 requests a loop while slot 0 also does.
- R10: Loop-back. While the count is nonzero and the address equals the loop end, the count drops by 1 and the next address is the loop start + 1. This overrides branch and jump targets.
- R11: End flag. An instruction with bit 43 set lets exactly one more instruction execute. The run then halts with `done`=1.
- R12: Double state read. An instruction whose two opcodes are both 4 gets no slot enables. It halts the run with `fault`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start a run at address 0 when idle |
| imem_addr | output | IP_W | Instruction memory read address |
| imem_rdata | input | 44 | Instruction word at `imem_addr`, same cycle |
| pred_value | input | DATA_W | Predicate register value |
| cmp_result | input | 2 | Compare outcome of ALU slot 0 (bit 0) and slot 1 (bit 1) |
| loop_val0 | input | DATA_W | Loop count operand from ALU slot 0 |
| loop_val1 | input | DATA_W | Loop count operand from ALU slot 1 |
| slot_en | output | 4 | Enables for ALU0, ALU1, output 0, output 1 |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run ended normally |
| fault | output | 1 | Last run ended on a fault |
| loop_err | output | 1 | Sticky illegal-loop-request flag |

## Verification
The bench builds the block with IP_W = 6 and DATA_W = 32, so its 64-word program memory covers the whole address space. With that width, short jump and branch offsets reach out-of-range targets, loop ends past the top address and the wrap past address 63. These fault paths would need huge offsets at the default width. Random programs that mix branches, jumps, loops, stop codes and end flags run against a reference model in the bench. Directed programs then pin down the loop trip count, the stop code, the double state read, a backward branch below zero, a jump without its mark bit, a nested loop request and a fixed predicate mask.

// File: rtl/mseq_pkg.sv
// Package: shared widths, instruction word layout and opcodes for the macro sequencer.
// Assumes a 16-bit immediate per ALU slot and a 3-bit opcode per slot.
package mseq_pkg;
    localparam int IMM_W     = 16;
    localparam int OP_W      = 3;
    localparam int SLOT_N    = 4;
    localparam int ALU_N     = 2;
    localparam int INST_W    = ALU_N * IMM_W + ALU_N * OP_W + SLOT_N + 2;
    localparam int POL_BIT   = 15;
    localparam int BR_OFF_W  = 13;
    localparam int JMP_OFF_W = 15;
    localparam logic [BR_OFF_W-1:0] STOP_CODE = 13'h1000;

    localparam logic [OP_W-1:0] OPC_NOP    = 3'd0;
    localparam logic [OP_W-1:0] OPC_BRANCH = 3'd1;
    localparam logic [OP_W-1:0] OPC_JUMP   = 3'd2;
    localparam logic [OP_W-1:0] OPC_LOOP   = 3'd3;
    localparam logic [OP_W-1:0] OPC_STATE  = 3'd4;

    typedef struct packed {
        logic               end_next;
        logic               uncond;
        logic [SLOT_N-1:0]  expect_t;
        logic [OP_W-1:0]    op1;
        logic [OP_W-1:0]    op0;
        logic [IMM_W-1:0]   imm1;
        logic [IMM_W-1:0]   imm0;
    } inst_t;
endpackage

// File: rtl/mseq_pred_mask.sv
// Predicate mask: turns the predicate field and the predicate register into
// four slot enables (ALU0, ALU1, OUT0, OUT1). Assumes a nonzero register is "true".
module mseq_pred_mask
    import mseq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              allow,
    input  logic              uncond,
    input  logic [SLOT_N-1:0] expect_t,
    input  logic [DATA_W-1:0] pred_value,
    output logic [SLOT_N-1:0] slot_en
);
    logic truth;

    // Purpose: reduce the predicate register to a truth value.
    always_comb truth = |pred_value;

    for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
        // Purpose: enable one slot when unconditional or when expectation matches.
        always_comb slot_en[s] = allow && (uncond || (expect_t[s] == truth));
    end
endmodule

// File: rtl/mseq_slot_ctrl.sv
// Slot control: decodes the control-flow effect of one ALU slot (branch, jump,
// loop request, state read) and checks the redirect target against the address range.
// Assumes IP_W is smaller than IMM_W.
module mseq_slot_ctrl
    import mseq_pkg::*;
#(
    parameter int IP_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [OP_W-1:0]  op,
    input  logic [IMM_W-1:0] imm,
    input  logic             cmp,
    input  logic [IP_W-1:0]  ip,
    output logic             redirect,
    output logic [IP_W-1:0]  target,
    output logic             stop,
    output logic             fault,
    output logic             loop_req,
    output logic             state_op
);
    localparam int EXT_W = IMM_W + 2;

    logic [EXT_W-1:0] ip_ext, br_off, jp_off, dest;
    logic taken, sentinel, bad_mark, out_range;

    // Purpose: widen the address and both offset forms to a common width.
    always_comb begin
        ip_ext = EXT_W'(ip);
        br_off = {{(EXT_W-BR_OFF_W){imm[BR_OFF_W-1]}}, imm[BR_OFF_W-1:0]};
        jp_off = EXT_W'(imm[JMP_OFF_W-1:0]);
    end

    // Purpose: decide redirect, stop and encoding error for this slot.
    always_comb begin
        redirect = 1'b0;
        stop     = 1'b0;
        bad_mark = 1'b0;
        taken    = (cmp == imm[POL_BIT]);
        sentinel = (imm[BR_OFF_W-1:0] == STOP_CODE);
        dest     = ip_ext + br_off;
        if (en) begin
            case (op)
                OPC_BRANCH: begin
                    if (taken) begin
                        if (sentinel) stop = 1'b1;
                        else          redirect = 1'b1;
                    end
                end
                OPC_JUMP: begin
                    dest     = ip_ext + jp_off;
                    redirect = 1'b1;
                    bad_mark = !imm[POL_BIT];
                end
                default: ;
            endcase
        end
    end

    // Purpose: range check and slot-level outputs.
    always_comb begin
        out_range = (dest[EXT_W-1:IP_W] != '0);
        fault     = bad_mark || (redirect && out_range);
        target    = dest[IP_W-1:0];
        loop_req  = en && (op == OPC_LOOP);
        state_op  = (op == OPC_STATE);
    end

    AST_JUMP_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OPC_JUMP && !imm[POL_BIT]) |-> fault); // R7
endmodule

// File: rtl/mseq_loop_unit.sv
// Loop unit: holds the single-level counted loop (count, start, end), accepts
// loop requests from the two ALU slots and signals loop-back at the loop end.
// Assumes slot 0 has priority and a request while a count is live is an error.
module mseq_loop_unit
    import mseq_pkg::*;
#(
    parameter int IP_W   = 12,
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         step,
    input  logic [ALU_N-1:0]             req,
    input  logic [ALU_N-1:0][DATA_W-1:0] val,
    input  logic [ALU_N-1:0][IMM_W-1:0]  imm,
    input  logic [IP_W-1:0]              ip,
    output logic                         hit,
    output logic [IP_W-1:0]              back_ip,
    output logic                         err
);
    localparam int EXT_W = IMM_W + 2;

    logic [DATA_W-1:0] cnt_q;
    logic [IP_W-1:0]   start_q, end_q;
    logic              active;
    logic [ALU_N-1:0]  len_ok, start_req, err_req;
    logic [ALU_N-1:0][EXT_W-1:0] end_ext;
    logic              start_any;
    logic [DATA_W-1:0] new_cnt;
    logic [IP_W-1:0]   new_end;

    // Purpose: loop status seen by the current instruction.
    always_comb begin
        active  = (cnt_q != '0);
        hit     = active && (ip == end_q);
        back_ip = start_q + IP_W'(1);
    end

    for (genvar s = 0; s < ALU_N; s++) begin : g_req
        // Purpose: check the loop length and the end address of one slot's request.
        always_comb begin
            end_ext[s] = EXT_W'(ip) + EXT_W'(imm[s]) - EXT_W'(1);
            len_ok[s]  = (imm[s] >= IMM_W'(2)) && (end_ext[s][EXT_W-1:IP_W] == '0);
        end
        if (s == 0) begin : g_first
            // Purpose: slot 0 request is taken when legal and no loop is live.
            always_comb start_req[s] = req[s] && !active && len_ok[s];
        end else begin : g_rest
            // Purpose: later slots yield to any lower-numbered loop request.
            always_comb start_req[s] = req[s] && !(|req[s-1:0]) && !active && len_ok[s];
        end
        // Purpose: a request that is not taken is an error.
        always_comb err_req[s] = req[s] && !start_req[s];
    end

    // Purpose: pick the winning request and its loop parameters.
    always_comb begin
        start_any = |start_req;
        new_cnt   = '0;
        new_end   = '0;
        for (int s = ALU_N - 1; s >= 0; s--) begin
            if (start_req[s]) begin
                new_cnt = (val[s] == '0) ? '0 : val[s] - DATA_W'(1);
                new_end = end_ext[s][IP_W-1:0];
            end
        end
        err = step && (|err_req);
    end

    // Purpose: loop registers: clear on run start, load on request, count down on loop-back.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q   <= '0;
            start_q <= '0;
            end_q   <= '0;
        end else if (step) begin
            if (start_any) begin
                cnt_q   <= new_cnt;
                start_q <= ip;
                end_q   <= new_end;
            end else if (hit) begin
                cnt_q <= cnt_q - DATA_W'(1);
            end
        end
    end

    AST_LOOP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (end_q > start_q)); // R9
    AST_LOOP_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && hit) |=> (cnt_q == $past(cnt_q) - DATA_W'(1))); // R10
endmodule

// File: rtl/macro_seq.sv
// Macro sequencer top: owns the instruction pointer and run state. Combines the
// predicate mask, two slot controllers and the loop unit into the next-address
// choice and the halt/fault decision. Assumes the instruction memory answers in the same cycle.
module macro_seq
    import mseq_pkg::*;
#(
    parameter int IP_W   = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    output logic [IP_W-1:0]   imem_addr,
    input  logic [43:0]       imem_rdata,
    input  logic [DATA_W-1:0] pred_value,
    input  logic [1:0]        cmp_result,
    input  logic [DATA_W-1:0] loop_val0,
    input  logic [DATA_W-1:0] loop_val1,
    output logic [3:0]        slot_en,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic              loop_err
);
    inst_t                        inst;
    logic [IP_W-1:0]              ip_q;
    logic                         busy_q, done_q, fault_q, lerr_q, endp_q;
    logic                         dual_state, launch;
    logic [ALU_N-1:0]             s_redirect, s_stop, s_fault, s_loop, s_state;
    logic [ALU_N-1:0][IP_W-1:0]   s_target;
    logic [ALU_N-1:0][OP_W-1:0]   s_op;
    logic [ALU_N-1:0][IMM_W-1:0]  s_imm;
    logic [ALU_N-1:0][DATA_W-1:0] s_val;
    logic                         loop_hit, loop_err_p;
    logic [IP_W-1:0]              loop_back_ip, nxt_ip;
    logic                         any_redirect, any_stop, ctl_fault, seq_fault;
    logic                         halt_fault, halt_done;

    // Purpose: view the fetched word as fields and group per-slot operands.
    always_comb begin
        inst     = inst_t'(imem_rdata);
        s_op     = {inst.op1, inst.op0};
        s_imm    = {inst.imm1, inst.imm0};
        s_val    = {loop_val1, loop_val0};
        launch   = go && !busy_q;
    end

    // Purpose: two state reads in one instruction are illegal.
    always_comb dual_state = (inst.op0 == OPC_STATE) && (inst.op1 == OPC_STATE);

    mseq_pred_mask #(.DATA_W(DATA_W)) u_pred (
        .allow      (busy_q && !dual_state),
        .uncond     (inst.uncond),
        .expect_t   (inst.expect_t),
        .pred_value (pred_value),
        .slot_en    (slot_en)
    );

    for (genvar s = 0; s < ALU_N; s++) begin : g_alu
        mseq_slot_ctrl #(.IP_W(IP_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (slot_en[s]),
            .op       (s_op[s]),
            .imm      (s_imm[s]),
            .cmp      (cmp_result[s]),
            .ip       (ip_q),
            .redirect (s_redirect[s]),
            .target   (s_target[s]),
            .stop     (s_stop[s]),
            .fault    (s_fault[s]),
            .loop_req (s_loop[s]),
            .state_op (s_state[s])
        );
    end

    mseq_loop_unit #(.IP_W(IP_W), .DATA_W(DATA_W)) u_loop (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (launch),
        .step    (busy_q),
        .req     (s_loop),
        .val     (s_val),
        .imm     (s_imm),
        .ip      (ip_q),
        .hit     (loop_hit),
        .back_ip (loop_back_ip),
        .err     (loop_err_p)
    );

    // Purpose: choose the next address; loop-back beats redirects, slot 1 beats slot 0.
    always_comb begin
        any_redirect = |s_redirect;
        any_stop     = |s_stop;
        ctl_fault    = |s_fault;
        if (loop_hit)            nxt_ip = loop_back_ip;
        else if (s_redirect[1])  nxt_ip = s_target[1];
        else if (s_redirect[0])  nxt_ip = s_target[0];
        else                     nxt_ip = ip_q + IP_W'(1);
        seq_fault  = !loop_hit && !any_redirect && (ip_q == '1);
        halt_fault = busy_q && (dual_state || ctl_fault ||
                     (!(any_stop || endp_q) && seq_fault));
        halt_done  = busy_q && !halt_fault && (any_stop || endp_q);
    end

    // Purpose: run state, instruction pointer and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip_q    <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            lerr_q  <= 1'b0;
            endp_q  <= 1'b0;
        end else if (launch) begin
            ip_q    <= '0;
            busy_q  <= 1'b1;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            lerr_q  <= 1'b0;
            endp_q  <= 1'b0;
        end else if (busy_q) begin
            if (loop_err_p) lerr_q <= 1'b1;
            if (halt_fault) begin
                busy_q  <= 1'b0;
                fault_q <= 1'b1;
            end else if (halt_done) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end else begin
                ip_q   <= nxt_ip;
                endp_q <= inst.end_next;
            end
        end
    end

    // Purpose: drive the ports from state.
    always_comb begin
        imem_addr = ip_q;
        busy      = busy_q;
        done      = done_q;
        fault     = fault_q;
        loop_err  = lerr_q;
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !go) |=> $stable(imem_addr)); // R2
    AST_IDLE_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (slot_en == 4'b0000)); // R3
    AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !busy); // R8
    AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R11
    AST_STOP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && any_stop && !halt_fault) |=> (done && !busy)); // R6
    AST_DUAL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && inst.op0 == OPC_STATE && inst.op1 == OPC_STATE) |=> (fault && !busy)); // R12
endmodule

// File: tb/macro_seq_tb.sv
module macro_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int IP_W   = 6;
    localparam int DEPTH  = 1 << IP_W;
    localparam int DATA_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    logic [IP_W-1:0] imem_addr;
    logic [43:0] imem_rdata;
    logic [DATA_W-1:0] pred_value = '0, loop_val0 = '0, loop_val1 = '0;
    logic [1:0] cmp_result = '0;
    logic [3:0] slot_en;
    logic busy, done, fault, loop_err;

    logic [43:0] prog [0:DEPTH-1];
    int n_chk = 0, n_err = 0, n_busy = 0;
    bit rnd_mode = 1'b0;
    logic [31:0] f_pred = '0, f_lv0 = '0, f_lv1 = '0;
    logic [1:0]  f_cmp = '0;

    // reference model state
    int m_ip, m_st, m_end;
    logic [31:0] m_cnt;
    bit m_busy, m_done, m_fault, m_lerr, m_endp;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign imem_rdata = prog[imem_addr];

    macro_seq #(.IP_W(IP_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .go(go), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .pred_value(pred_value), .cmp_result(cmp_result), .loop_val0(loop_val0),
        .loop_val1(loop_val1), .slot_en(slot_en), .busy(busy), .done(done),
        .fault(fault), .loop_err(loop_err)
    );

    function automatic logic [43:0] mk(bit e, bit u, logic [3:0] ex, logic [2:0] o1,
                                       logic [2:0] o0, logic [15:0] i1, logic [15:0] i0);
        return {e, u, ex, o1, o0, i1, i0};
    endfunction

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] exp_mask(logic [43:0] w, logic [31:0] pv);
        logic [3:0] m;
        if (!m_busy) return 4'b0000;
        if (w[34:32] == 3'd4 && w[37:35] == 3'd4) return 4'b0000;
        if (w[42]) return 4'b1111;
        for (int i = 0; i < 4; i++) m[i] = (w[38+i] == (pv != 0));
        return m;
    endfunction

    task automatic m_reset();
        m_ip = 0; m_st = 0; m_end = 0; m_cnt = '0;
        m_busy = 0; m_done = 0; m_fault = 0; m_lerr = 0; m_endp = 0;
    endtask

    task automatic m_step(logic [43:0] w, logic [31:0] pv, logic [1:0] c,
                          logic [31:0] lv0, logic [31:0] lv1, bit g);
        logic [3:0] en;
        bit red = 0, stp = 0, flt = 0, nl = 0, hit;
        int tgt = 0, nxt, t, off, nl_end = 0;
        logic [31:0] nl_cnt = '0;
        if (!m_busy) begin
            if (g) begin m_reset(); m_busy = 1; end
            return;
        end
        en = exp_mask(w, pv);
        if (w[34:32] == 3'd4 && w[37:35] == 3'd4) begin m_busy = 0; m_fault = 1; return; end
        hit = (m_cnt != 0) && (m_ip == m_end);
        for (int i = 0; i < 2; i++) begin
            logic [2:0] op = i ? w[37:35] : w[34:32];
            logic [15:0] imm = i ? w[31:16] : w[15:0];
            logic [31:0] x = i ? lv1 : lv0;
            if (!en[i]) continue;
            if (op == 3'd1) begin
                if (c[i] == imm[15]) begin
                    if (imm[12:0] == 13'h1000) stp = 1;
                    else begin
                        off = imm[12] ? int'(imm[12:0]) - 8192 : int'(imm[12:0]);
                        t = m_ip + off;
                        if (t < 0 || t >= DEPTH) flt = 1; else begin red = 1; tgt = t; end
                    end
                end
            end else if (op == 3'd2) begin
                t = m_ip + int'(imm[14:0]);
                if (!imm[15] || t >= DEPTH) flt = 1; else begin red = 1; tgt = t; end
            end else if (op == 3'd3) begin
                if (i == 1 && en[0] && w[34:32] == 3'd3) m_lerr = 1;
                else if (m_cnt != 0) m_lerr = 1;
                else if (imm < 2 || m_ip + int'(imm) - 1 >= DEPTH) m_lerr = 1;
                else begin
                    nl = 1; nl_cnt = (x == 0) ? 0 : x - 1; nl_end = m_ip + int'(imm) - 1;
                end
            end
        end
        nxt = hit ? m_st + 1 : (red ? tgt : m_ip + 1);
        if (nl) begin m_cnt = nl_cnt; m_st = m_ip; m_end = nl_end; end
        else if (hit) m_cnt = m_cnt - 1;
        if (flt) begin m_busy = 0; m_fault = 1; end
        else if (stp || m_endp) begin m_busy = 0; m_done = 1; end
        else if (nxt >= DEPTH) begin m_busy = 0; m_fault = 1; end
        else begin m_ip = nxt; m_endp = w[43]; end
    endtask

    task automatic cyc(bit g);
        logic [43:0] w;
        @(negedge clk);
        go = g;
        if (rnd_mode) begin
            pred_value = ($urandom % 3 == 0) ? 32'd0 : $urandom;
            cmp_result = 2'($urandom % 4);
            loop_val0 = $urandom % 5;
            loop_val1 = $urandom % 5;
        end else begin
            pred_value = f_pred; cmp_result = f_cmp; loop_val0 = f_lv0; loop_val1 = f_lv1;
        end
        #1;
        w = prog[m_ip[IP_W-1:0]];
        chk("R4 imem_addr", 32'(imem_addr), 32'(m_ip));
        chk("R3 slot_en", 32'(slot_en), 32'(exp_mask(w, pred_value)));
        chk("R2 busy", 32'(busy), 32'(m_busy));
        chk("R11 done", 32'(done), 32'(m_done));
        chk("R8 fault", 32'(fault), 32'(m_fault));
        chk("R9 loop_err", 32'(loop_err), 32'(m_lerr));
        if (busy) n_busy++;
        m_step(w, pred_value, cmp_result, loop_val0, loop_val1, g);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; go = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        m_reset();
    endtask

    task automatic run(int maxc);
        n_busy = 0;
        cyc(1'b1);
        for (int k = 0; k < maxc && m_busy; k++) cyc(rnd_mode && ($urandom % 16 == 0));
        cyc(1'b0);
    endtask

    task automatic clear_prog();
        for (int a = 0; a < DEPTH; a++) prog[a] = mk(0, 1, 4'h0, 3'd0, 3'd0, 16'h0, 16'h0);
    endtask

    function automatic logic [18:0] rnd_slot();
        int r = $urandom % 100;
        int off;
        logic [12:0] low;
        if (r < 45) return {(($urandom % 2) != 0) ? 3'd0 : 3'(5 + $urandom % 3), 16'($urandom)};
        if (r < 62) begin
            off = int'($urandom % 13) - 6;
            low = ($urandom % 20 == 0) ? 13'h1000 : off[12:0];
            return {3'd1, 1'($urandom % 2), 2'b00, low};
        end
        if (r < 72) return {3'd2, 1'($urandom % 8 != 0), 15'($urandom % 10)};
        if (r < 90) return {3'd3, 16'($urandom % 7)};
        return {3'd4, 16'($urandom)};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
    end

    initial begin
        logic [18:0] s0, s1;
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        clear_prog();
        m_reset();
        repeat (3) @(negedge clk);
        #1;
        // R1: reset values
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 fault", 32'(fault), 0);
        chk("R1 loop_err", 32'(loop_err), 0);
        chk("R1 slot_en", 32'(slot_en), 0);
        chk("R1 imem_addr", 32'(imem_addr), 0);
        rst_n = 1;

        // R10/R11: loop of 3 over 1..2, end flag at 3 -> trace 0,1,2,1,2,1,2,3,4
        clear_prog();
        prog[0] = mk(0, 1, 4'h0, 3'd0, 3'd3, 16'h0, 16'd3);
        prog[3] = mk(1, 1, 4'h0, 3'd0, 3'd0, 16'h0, 16'h0);
        f_lv0 = 3; f_pred = 0; f_cmp = 0; rnd_mode = 0;
        run(40);
        chk("R10 loop trip cycles", 32'(n_busy), 9);
        chk("R11 end flag done", 32'(done), 1);
        chk("R11 halt address", 32'(imem_addr), 4);

        // R6: stop code in slot 1
        do_reset(); clear_prog();
        prog[0] = mk(0, 1, 4'h0, 3'd1, 3'd0, 16'h9000, 16'h0);
        f_cmp = 2'b10;
        run(10);
        chk("R6 stop done", 32'(done), 1);
        chk("R6 stop cycles", 32'(n_busy), 1);
        chk("R6 stop address", 32'(imem_addr), 0);

        // R12: double state read
        do_reset(); clear_prog();
        prog[0] = mk(0, 1, 4'h0, 3'd4, 3'd4, 16'h0, 16'h0);
        run(10);
        chk("R12 dual state fault", 32'(fault), 1);
        chk("R12 dual state not done", 32'(done), 0);

        // R8: taken backward branch below zero
        do_reset(); clear_prog();
        prog[0] = mk(0, 1, 4'h0, 3'd0, 3'd1, 16'h0, 16'h9FFF);
        f_cmp = 2'b01;
        run(10);
        chk("R8 negative target fault", 32'(fault), 1);

        // R7: jump without mark bit faults; with mark bit jumps
        do_reset(); clear_prog();
        prog[0] = mk(0, 1, 4'h0, 3'd0, 3'd2, 16'h0, 16'h0003);
        run(10);
        chk("R7 unmarked jump fault", 32'(fault), 1);
        do_reset(); clear_prog();
        prog[0] = mk(0, 1, 4'h0, 3'd0, 3'd2, 16'h0, 16'h8005);
        prog[5] = mk(1, 1, 4'h0, 3'd0, 3'd0, 16'h0, 16'h0);
        run(10);
        chk("R7 marked jump address", 32'(imem_addr), 6);
        chk("R7 marked jump done", 32'(done), 1);

        // R9: loop request while a loop is live
        do_reset(); clear_prog();
        prog[0] = mk(0, 1, 4'h0, 3'd0, 3'd3, 16'h0, 16'd4);
        prog[1] = mk(0, 1, 4'h0, 3'd0, 3'd3, 16'h0, 16'd3);
        prog[8] = mk(1, 1, 4'h0, 3'd0, 3'd0, 16'h0, 16'h0);
        f_lv0 = 5; f_cmp = 0;
        run(60);
        chk("R9 nested loop error", 32'(loop_err), 1);
        chk("R9 outer loop kept", 32'(done), 1);

        // R3: fixed predicate mask, expect 0101 with a true register
        do_reset(); clear_prog();
        prog[0] = mk(1, 0, 4'b0101, 3'd0, 3'd0, 16'h0, 16'h0);
        f_pred = 32'h40;
        cyc(1'b1);
        @(negedge clk); #1;
        chk("R3 mask 0101", 32'(slot_en), 32'h5);
        m_reset();

        // R5 and all: random programs against the model
        rnd_mode = 1;
        for (int p = 0; p < 80; p++) begin
            do_reset();
            for (int a = 0; a < DEPTH; a++) begin
                s0 = rnd_slot(); s1 = rnd_slot();
                prog[a] = mk(($urandom % 20) == 0, ($urandom % 5) < 2, 4'($urandom),
                             s1[18:16], s0[18:16], s1[15:0], s0[15:0]);
            end
            run(200);
        end
        report();
    end
endmodule